// File: doc/BRIEF.md
# Time Transfer Target Decoder

This block chooses which core on the chip receives the next time-of-day to timebase transfer, and it starts that transfer when told to. Software programs a target by writing a control word. That word names the target in one of two ways. It can give a complete register address, which is matched against a table of per-core base addresses. It can also give a plain core number. The decoded target is held in a latch until the next control write.

A later move command checks four conditions: the time-of-day controller is running, the command bit is set, a target is held, and that core reports it is ready to accept a value. When all four hold, the block pulses the send line of that one core for a single cycle. Each condition that fails raises its own error pulse, and nothing is sent. The core-side timebase logic and the transport that carries the value are outside this block.

Top module: `tod_xfer_target`

## Requirements
- R1: After reset the target latch is invalid (`tgt_valid`=0, `tgt_core`=0), all send lines are low and all error pulses are low.
- R2: A write to offset 0x27 with `wr_data[28]` set selects full-address mode, with the address taken from `wr_data[63:32]`. When address bits [11:0] equal 0x4A3 and address bits [31:12] equal bits [31:12] of core i's base, one cycle later `tgt_valid`=1 and `tgt_core`=i. The lowest matching index wins.
- R3: In full-address mode, an address whose low 12 bits are not 0x4A3, or whose upper bits match no core base, makes `tgt_valid`=0 and pulses `err_decode` for one cycle, one cycle after the write.
- R4: With `wr_data[28]` clear and core-number mode enabled, the core number is `wr_data[36:32]`. Bit 37 is ignored. A number below NUM_CORES becomes the valid target.
- R5: In core-number mode, a number of NUM_CORES or more makes the target invalid and pulses `err_decode`.
- R6: With CORE_ID_MODE_EN=0, every control write with `wr_data[28]` clear makes the target invalid and pulses `err_decode`, while full-address mode still decodes.
- R7: A write to offset 0x17 when `tod_running`=1, `wr_data[63]`=1, the target is valid and `core_ready[tgt_core]`=1 drives `send_pulse` to the one-hot code of `tgt_core` in the next cycle only.
- R8: A move while `tod_running`=0 pulses `err_state` and sends nothing.
- R9: A move with `wr_data[63]`=0 pulses `err_cmd` and sends nothing.
- R10: A move while no valid target is held pulses `err_no_target` and sends nothing.
- R11: A move to a valid target whose `core_ready` bit is low pulses `err_not_ready` and sends nothing.
- R12: Writes to any offset other than 0x27 leave the target latch unchanged. This includes failed moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_off | input | 6 | Register offset of the write |
| wr_data | input | 64 | Write data; bit 63 is the most significant |
| tod_running | input | 1 | Time-of-day controller is in its running state |
| core_ready | input | NUM_CORES | Per-core readiness to accept a value |
| send_pulse | output | NUM_CORES | One-hot, one-cycle transfer launch |
| tgt_valid | output | 1 | A decoded target is held |
| tgt_core | output | IDX_W | Index of the held target core |
| err_decode | output | 1 | Control write could not be decoded |
| err_state | output | 1 | Move refused: controller not running |
| err_cmd | output | 1 | Move refused: command bit clear |
| err_no_target | output | 1 | Move refused: no valid target |
| err_not_ready | output | 1 | Move refused: target core not ready |

## Verification
The bench builds two copies of the block. Both have four cores at bases 0x2000_0000 through 0x2300_0000. One has core-number mode enabled and the other has it disabled, so the same control writes show both variants side by side (R6). With four cores, a 5-bit core number can easily go out of range, and the masked bit 37 can be exercised together with an in-range number.

// File: rtl/tod_xfer_target.sv
module tod_xfer_target #(
  parameter int NUM_CORES = 4,
  parameter bit CORE_ID_MODE_EN = 1'b1,
  parameter logic [NUM_CORES*32-1:0] CORE_BASES =
    {32'h2300_0000, 32'h2200_0000, 32'h2100_0000, 32'h2000_0000},
  parameter logic [5:0] OFS_MOVE = 6'h17,
  parameter logic [5:0] OFS_TARGET = 6'h27,
  parameter logic [11:0] TB_REG_LOW = 12'h4A3,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [5:0]           wr_off,
  input  logic [63:0]          wr_data,
  input  logic                 tod_running,
  input  logic [NUM_CORES-1:0] core_ready,
  output logic [NUM_CORES-1:0] send_pulse,
  output logic                 tgt_valid,
  output logic [IDX_W-1:0]     tgt_core,
  output logic                 err_decode,
  output logic                 err_state,
  output logic                 err_cmd,
  output logic                 err_no_target,
  output logic                 err_not_ready
);

  logic [31:0] taddr;
  logic        full_mode;
  logic [4:0]  cid;
  logic        addr_hit;
  logic [IDX_W-1:0] addr_idx;
  logic        id_ok, dec_ok;
  logic [IDX_W-1:0] dec_idx;
  logic        ctl_wr, mv_wr, sel_ready, go;
  logic        unused_bits;

  assign taddr     = wr_data[63:32];
  assign full_mode = wr_data[28];
  assign cid       = wr_data[36:32];
  assign unused_bits = ^{wr_data[31:29], wr_data[27:0]};

  always_comb begin
    addr_hit = 1'b0;
    addr_idx = '0;
    for (int i = NUM_CORES - 1; i >= 0; i--) begin
      if (taddr[31:12] == CORE_BASES[i*32+12 +: 20]) begin
        addr_hit = 1'b1;
        addr_idx = IDX_W'(i);
      end
    end
  end

  assign id_ok   = CORE_ID_MODE_EN && (int'(cid) < NUM_CORES);
  assign dec_ok  = full_mode ? ((taddr[11:0] == TB_REG_LOW) && addr_hit) : id_ok;
  assign dec_idx = full_mode ? addr_idx : IDX_W'(cid);

  assign ctl_wr    = wr_en && (wr_off == OFS_TARGET);
  assign mv_wr     = wr_en && (wr_off == OFS_MOVE);
  assign sel_ready = core_ready[tgt_core];
  assign go        = mv_wr && tod_running && wr_data[63] && tgt_valid && sel_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_valid     <= 1'b0;
      tgt_core      <= '0;
      send_pulse    <= '0;
      err_decode    <= 1'b0;
      err_state     <= 1'b0;
      err_cmd       <= 1'b0;
      err_no_target <= 1'b0;
      err_not_ready <= 1'b0;
    end else begin
      if (ctl_wr) begin
        tgt_valid <= dec_ok;
        tgt_core  <= dec_ok ? dec_idx : '0;
      end
      send_pulse    <= go ? (NUM_CORES'(1) << tgt_core) : '0;
      err_decode    <= ctl_wr && !dec_ok;
      err_state     <= mv_wr && !tod_running;
      err_cmd       <= mv_wr && !wr_data[63];
      err_no_target <= mv_wr && !tgt_valid;
      err_not_ready <= mv_wr && tgt_valid && !sel_ready;
    end
  end

endmodule

// File: rtl/tod_xfer_target_chk.sv
module tod_xfer_target_chk #(
  parameter int NUM_CORES = 4,
  parameter int IDX_W = 2,
  parameter logic [5:0] OFS_MOVE = 6'h17,
  parameter logic [5:0] OFS_TARGET = 6'h27
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [5:0]           wr_off,
  input logic [63:0]          wr_data,
  input logic                 tod_running,
  input logic [NUM_CORES-1:0] send_pulse,
  input logic                 tgt_valid,
  input logic [IDX_W-1:0]     tgt_core,
  input logic                 err_decode,
  input logic                 err_state,
  input logic                 err_not_ready
);

  // R7
  send_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(send_pulse));

  // R7
  send_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|send_pulse) |-> $past(wr_en && wr_off == OFS_MOVE && tod_running
                            && wr_data[63] && tgt_valid));

  // R3
  decode_err_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_decode |-> !tgt_valid);

  // R8
  state_err_nosend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_state |-> (send_pulse == '0));

  // R11
  not_ready_had_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_not_ready |-> $past(tgt_valid) && (send_pulse == '0));

  // R12
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en && wr_off == OFS_TARGET) |-> ($stable(tgt_valid) && $stable(tgt_core)));

endmodule

bind tod_xfer_target tod_xfer_target_chk #(
  .NUM_CORES(NUM_CORES), .IDX_W(IDX_W), .OFS_MOVE(OFS_MOVE), .OFS_TARGET(OFS_TARGET)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
  .tod_running(tod_running), .send_pulse(send_pulse), .tgt_valid(tgt_valid),
  .tgt_core(tgt_core), .err_decode(err_decode), .err_state(err_state),
  .err_not_ready(err_not_ready)
);

// File: tb/tod_xfer_target_bench.sv
module tod_xfer_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, tod_running = 1'b0;
  logic [5:0] wr_off = '0;
  logic [63:0] wr_data = '0;
  logic [NC-1:0] core_ready = '0;

  logic [NC-1:0] send_pulse, n_send;
  logic tgt_valid, err_decode, err_state, err_cmd, err_no_target, err_not_ready;
  logic [1:0] tgt_core, n_core;
  logic n_valid, n_dec, n_st, n_cmd, n_nt, n_nr;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_xfer_target u_tod_xfer_target (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
    .tod_running(tod_running), .core_ready(core_ready), .send_pulse(send_pulse),
    .tgt_valid(tgt_valid), .tgt_core(tgt_core), .err_decode(err_decode),
    .err_state(err_state), .err_cmd(err_cmd), .err_no_target(err_no_target),
    .err_not_ready(err_not_ready));

  tod_xfer_target #(.CORE_ID_MODE_EN(1'b0)) u_noid (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
    .tod_running(tod_running), .core_ready(core_ready), .send_pulse(n_send),
    .tgt_valid(n_valid), .tgt_core(n_core), .err_decode(n_dec),
    .err_state(n_st), .err_cmd(n_cmd), .err_no_target(n_nt),
    .err_not_ready(n_nr));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one write; returns at the negedge after the capturing posedge
  task automatic wr(input logic [5:0] off, input logic [63:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_off = off; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic logic [63:0] full_addr(input logic [31:0] a);
    return {a, 32'h1000_0000};
  endfunction

  function automatic logic [63:0] core_num(input logic [5:0] f);
    return {26'b0, f, 32'h0};
  endfunction

  task automatic t_reset();
    check("R1 valid", tgt_valid, 0);
    check("R1 core", tgt_core, 0);
    check("R1 send", send_pulse, 0);
    check("R1 errs", {err_decode, err_state, err_cmd, err_no_target, err_not_ready}, 0);
  endtask

  task automatic t_full_addr();
    wr(6'h27, full_addr(32'h2200_04A3));
    check("R2 valid", tgt_valid, 1);
    check("R2 core", tgt_core, 2);
    check("R2 no err", err_decode, 0);
    check("R6 full mode still decodes", {n_valid, n_core}, {1'b1, 2'd2});
    wr(6'h27, full_addr(32'h2200_04A4));
    check("R3 bad low valid", tgt_valid, 0);
    check("R3 bad low err", err_decode, 1);
    @(negedge clk);
    check("R3 err one cycle", err_decode, 0);
    wr(6'h27, full_addr(32'h3000_04A3));
    check("R3 no base valid", tgt_valid, 0);
    check("R3 no base err", err_decode, 1);
  endtask

  task automatic t_core_id();
    wr(6'h27, core_num(6'b100011));
    check("R4 valid", tgt_valid, 1);
    check("R4 core masked", tgt_core, 3);
    check("R6 noid invalid", n_valid, 0);
    check("R6 noid err", n_dec, 1);
    wr(6'h27, core_num(6'd5));
    check("R5 out of range valid", tgt_valid, 0);
    check("R5 out of range err", err_decode, 1);
  endtask

  task automatic t_move_ok();
    wr(6'h27, core_num(6'd1));
    core_ready = 4'b0010; tod_running = 1'b1;
    wr(6'h17, 64'h8000_0000_0000_0000);
    check("R7 send", send_pulse, 4'b0010);
    check("R7 no errs", {err_state, err_cmd, err_no_target, err_not_ready}, 0);
    @(negedge clk);
    check("R7 single cycle", send_pulse, 0);
  endtask

  task automatic t_move_fail();
    tod_running = 1'b0;
    wr(6'h17, 64'h8000_0000_0000_0000);
    check("R8 err", err_state, 1);
    check("R8 no send", send_pulse, 0);
    tod_running = 1'b1;
    wr(6'h17, 64'h7fff_ffff_ffff_ffff);
    check("R9 err", err_cmd, 1);
    check("R9 no send", send_pulse, 0);
    core_ready = 4'b1101;
    wr(6'h17, 64'h8000_0000_0000_0000);
    check("R11 err", err_not_ready, 1);
    check("R11 no send", send_pulse, 0);
    core_ready = 4'b1111;
    wr(6'h27, core_num(6'd9));
    wr(6'h17, 64'h8000_0000_0000_0000);
    check("R10 err", err_no_target, 1);
    check("R10 no send", send_pulse, 0);
  endtask

  task automatic t_other_offsets();
    wr(6'h27, full_addr(32'h2300_04A3));
    wr(6'h18, full_addr(32'h2000_04A3));
    wr(6'h26, core_num(6'd0));
    check("R12 valid kept", tgt_valid, 1);
    check("R12 core kept", tgt_core, 3);
    tod_running = 1'b0;
    wr(6'h17, 64'h8000_0000_0000_0000);
    tod_running = 1'b1;
    wr(6'h17, 64'h8000_0000_0000_0000);
    check("R12 target survives failed move", send_pulse, 4'b1000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_addr();
    t_core_id();
    t_move_ok();
    t_move_fail();
    t_other_offsets();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule